// File: doc/BRIEF.md
# PWM Reload Status Flag Unit

This block keeps the status flags and interrupt enables for one PWM channel group whose period, compare and prescaler settings sit in a double-buffered register set. It watches writes to the buffered set and reload pulses from the timer. From these it records whether the buffered values have been changed since the last load. It also records a reload that arrived while those values were still waiting for their load-OK permission.

It also holds one sticky flag for each of the six compare-match pulses from the counter, and a reload flag. The reload flag is cleared either by software or by a DMA-done pulse, depending on the DMA-mode input. Software clears the error, reload and compare flags by writing ones to them. Every enabled flag feeds one registered interrupt request.

Registers are 16 bits wide. Bits are numbered here by their numeric weight, with bit 15 the most significant.

Top module: `pwm_reload_status`

## Requirements
- R1: After reset, `sts_rd`, `ien_rd` and `irq` are all zero.
- R2: A cycle with `buf_wr` high sets the pending-update flag at `sts_rd[14]` on the next edge. A status write cannot clear this flag, whatever the data.
- R3: A `reload` pulse with `load_ok` high clears the pending-update flag. A `reload` with `load_ok` low leaves it unchanged.
- R4: When `buf_wr` and a `reload` with `load_ok` high occur in the same cycle, the pending-update flag ends up set.
- R5: The reload-error flag at `sts_rd[13]` is set by a `reload` with `load_ok` low, but only while the pending-update flag is already set. With the pending-update flag clear, such a reload leaves the error flag clear.
- R6: A status write with `wdata[13]` high clears the reload-error flag. A status write with that bit low leaves the flag unchanged.
- R7: Every `reload` pulse sets the reload flag at `sts_rd[12]`, whatever the value of `load_ok`.
- R8: While `dma_mode` is low, a status write with `wdata[12]` high clears the reload flag, and `dma_done` has no effect on it.
- R9: While `dma_mode` is high, a `dma_done` pulse clears the reload flag, and status writes have no effect on it.
- R10: A high `cmp_hit[k]` sets the compare flag `sts_rd[k]` (k = 0..5). A status write clears exactly those compare flags whose `wdata` bits are one.
- R11: When a set event and a write-one-to-clear reach the same flag in the same cycle, the flag is set.
- R12: An enable write stores `wdata` masked to bits 13 (reload-error enable), 12 (reload enable) and 5..0 (compare enables). All other bits of `ien_rd` read zero, and bits 15, 11..6 of `sts_rd` read zero.
- R13: `irq` is high in the cycle after one in which any flag at bit 13, 12 or 5..0 of `sts_rd` is set together with the same bit of `ien_rd`. Otherwise `irq` is low in that next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_wr | input | 1 | Strobe: a buffered init, compare or prescaler field is being written |
| sts_wr | input | 1 | Strobe: status write (write-one-to-clear) |
| ien_wr | input | 1 | Strobe: interrupt-enable write |
| wdata | input | 16 | Write data for the status and enable registers |
| reload | input | 1 | Reload pulse from the timer |
| load_ok | input | 1 | Permission to load the buffered set |
| dma_mode | input | 1 | Selects the DMA-done pulse as the clear source for the reload flag |
| dma_done | input | 1 | DMA completion pulse |
| cmp_hit | input | 6 | Compare-match pulses, one for each compare value |
| sts_rd | output | 16 | Status register value |
| ien_rd | output | 16 | Interrupt-enable register value |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the inputs are held at zero while reset is applied. This lets every `|=>` check start cleanly on the first edge after reset is released. They also assume that the write strobes, `reload`, `dma_done` and `cmp_hit` are sampled as single-cycle levels, with no protocol between them. The stimulus changes every input only on the falling edge and returns the strobes to zero between operations unless a case combines them deliberately. It also covers collisions, such as a set and a clear of the same flag in one cycle, or a buffered write during a valid reload. Each of these collisions is driven as a single cycle, so the outcome of each priority rule is visible on its own.

// File: rtl/pwm_status_pkg.sv
package pwm_status_pkg;
   // Numeric bit positions inside a status/enable word of width w
   function automatic int upd_pos(input int w);
      return w - 2;
   endfunction
   function automatic int err_pos(input int w);
      return w - 3;
   endfunction
   function automatic int rld_pos(input int w);
      return w - 4;
   endfunction
endpackage

// File: rtl/pwm_coherence_flags.sv
module pwm_coherence_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic buf_wr,
   input  logic reload,
   input  logic load_ok,
   input  logic dma_mode,
   input  logic dma_done,
   input  logic clr_err,
   input  logic clr_rld,
   output logic upd_f,
   output logic err_f,
   output logic rld_f
);
   logic good_load, bad_load, rld_clear;

   assign good_load = reload & load_ok;
   assign bad_load  = reload & ~load_ok & upd_f;
   assign rld_clear = dma_mode ? dma_done : clr_rld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_f <= 1'b0;
         err_f <= 1'b0;
         rld_f <= 1'b0;
      end else begin
         // new unloaded data beats a simultaneous load
         if (buf_wr)         upd_f <= 1'b1;
         else if (good_load) upd_f <= 1'b0;

         if (bad_load)     err_f <= 1'b1;
         else if (clr_err) err_f <= 1'b0;

         if (reload)         rld_f <= 1'b1;
         else if (rld_clear) rld_f <= 1'b0;
      end
   end

   // R2
   upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr |=> upd_f);
   // R3
   upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (good_load && !buf_wr) |=> !upd_f);
   // R5
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !load_ok && upd_f) |=> err_f);
   // R7
   rld_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> rld_f);
   // R8
   rld_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_mode && clr_rld && !reload) |=> !rld_f);
   // R9
   rld_dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_mode && rld_f && !dma_done) |=> rld_f);
endmodule

// File: rtl/pwm_compare_flags.sv
module pwm_compare_flags #(
   parameter int NUM_CMP = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CMP-1:0] hit,
   input  logic [NUM_CMP-1:0] clr,
   output logic [NUM_CMP-1:0] flag
);
   for (genvar k = 0; k < NUM_CMP; k++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[k] <= 1'b0;
         else if (hit[k]) flag[k] <= 1'b1;
         else if (clr[k]) flag[k] <= 1'b0;
      end

      // R10 R11
      cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit[k] |=> flag[k]);
      // R10
      cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[k] && !hit[k]) |=> !flag[k]);
   end
endmodule

// File: rtl/pwm_irq_merge.sv
module pwm_irq_merge #(
   parameter int W       = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags,
   input  logic [W-1:0] enables,
   output logic         irq
);
   logic any_req;
   assign any_req = |(flags & enables);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_req;
      end

      // R13
      irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         any_req |=> irq);
      // R13
      irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !any_req |=> !irq);
   end else begin : g_comb
      assign irq = any_req;
   end
endmodule

// File: rtl/pwm_reload_status.sv
module pwm_reload_status
   import pwm_status_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter int NUM_CMP = 6,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               buf_wr,
   input  logic               sts_wr,
   input  logic               ien_wr,
   input  logic [REG_W-1:0]   wdata,
   input  logic               reload,
   input  logic               load_ok,
   input  logic               dma_mode,
   input  logic               dma_done,
   input  logic [NUM_CMP-1:0] cmp_hit,
   output logic [REG_W-1:0]   sts_rd,
   output logic [REG_W-1:0]   ien_rd,
   output logic               irq
);
   localparam int UPD = upd_pos(REG_W);
   localparam int ERR = err_pos(REG_W);
   localparam int RLD = rld_pos(REG_W);
   localparam int IRQ_W = NUM_CMP + 2;
   localparam logic [REG_W-1:0] IEN_MASK =
      (REG_W'(1) << ERR) | (REG_W'(1) << RLD) | REG_W'((1 << NUM_CMP) - 1);

   if (NUM_CMP < 1 || NUM_CMP > RLD) begin : g_bad_cmp
      $error("pwm_reload_status: NUM_CMP must lie between 1 and REG_W-4");
   end
   if (REG_W < 8) begin : g_bad_w
      $error("pwm_reload_status: REG_W must be at least 8");
   end

   logic               upd_f, err_f, rld_f;
   logic [NUM_CMP-1:0] cmp_f;
   logic [REG_W-1:0]   ien_q;

   pwm_coherence_flags u_coh (
      .clk      (clk),
      .rst_n    (rst_n),
      .buf_wr   (buf_wr),
      .reload   (reload),
      .load_ok  (load_ok),
      .dma_mode (dma_mode),
      .dma_done (dma_done),
      .clr_err  (sts_wr & wdata[ERR]),
      .clr_rld  (sts_wr & wdata[RLD]),
      .upd_f    (upd_f),
      .err_f    (err_f),
      .rld_f    (rld_f)
   );

   pwm_compare_flags #(.NUM_CMP(NUM_CMP)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (cmp_hit),
      .clr   ({NUM_CMP{sts_wr}} & wdata[NUM_CMP-1:0]),
      .flag  (cmp_f)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (ien_wr) ien_q <= wdata & IEN_MASK;
   end

   always_comb begin
      sts_rd               = '0;
      sts_rd[UPD]          = upd_f;
      sts_rd[ERR]          = err_f;
      sts_rd[RLD]          = rld_f;
      sts_rd[NUM_CMP-1:0]  = cmp_f;
   end
   assign ien_rd = ien_q;

   pwm_irq_merge #(.W(IRQ_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   ({err_f, rld_f, cmp_f}),
      .enables ({ien_q[ERR], ien_q[RLD], ien_q[NUM_CMP-1:0]}),
      .irq     (irq)
   );

   // R12
   ien_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ien_wr |=> ien_rd == ($past(wdata) & IEN_MASK));
   // R2
   upd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd[UPD] && !reload) |=> sts_rd[UPD]);
endmodule

// File: tb/pwm_reload_status_test.sv
module pwm_reload_status_test;
   localparam int PERIOD = 10;

   typedef struct {
      logic [15:0] sts;
      logic [15:0] ien;
      logic        irq;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        buf_wr = 0, sts_wr = 0, ien_wr = 0;
   logic [15:0] wdata = '0;
   logic        reload = 0, load_ok = 0, dma_mode = 0, dma_done = 0;
   logic [5:0]  cmp_hit = '0;
   logic [15:0] sts_rd, ien_rd;
   logic        irq;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 0;
   exp_t sb[$];

   logic [15:0] m_sts = '0, m_ien = '0;
   logic        m_irq = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   pwm_reload_status uut (
      .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .sts_wr(sts_wr),
      .ien_wr(ien_wr), .wdata(wdata), .reload(reload), .load_ok(load_ok),
      .dma_mode(dma_mode), .dma_done(dma_done), .cmp_hit(cmp_hit),
      .sts_rd(sts_rd), .ien_rd(ien_rd), .irq(irq)
   );

   task automatic step(input logic bw, input logic sw, input logic iw,
                       input logic [15:0] wd, input logic rl, input logic lo,
                       input logic dm, input logic dd, input logic [5:0] hit,
                       input string tag);
      logic [15:0] ns;
      exp_t e;
      @(negedge clk);
      buf_wr = bw; sts_wr = sw; ien_wr = iw; wdata = wd; reload = rl;
      load_ok = lo; dma_mode = dm; dma_done = dd; cmp_hit = hit;
      ns = m_sts;
      if (bw) ns[14] = 1'b1;
      else if (rl && lo) ns[14] = 1'b0;
      if (rl && !lo && m_sts[14]) ns[13] = 1'b1;
      else if (sw && wd[13]) ns[13] = 1'b0;
      if (rl) ns[12] = 1'b1;
      else if (dm ? dd : (sw && wd[12])) ns[12] = 1'b0;
      for (int k = 0; k < 6; k++) begin
         if (hit[k]) ns[k] = 1'b1;
         else if (sw && wd[k]) ns[k] = 1'b0;
      end
      m_irq = |(m_sts & m_ien & 16'h303F);
      if (iw) m_ien = wd & 16'h303F;
      m_sts = ns;
      e.sts = m_sts; e.ien = m_ien; e.irq = m_irq; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 16'h0, 0, 0, dma_mode, 0, 6'h0, tag);
   endtask

   // monitor: compares after each active edge
   initial begin
      forever begin
         @(posedge clk);
         #(PERIOD/4);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (sts_rd !== e.sts || ien_rd !== e.ien || irq !== e.irq) begin
               n_bad++;
               $display("FAIL %s: sts=%h ien=%h irq=%b expected sts=%h ien=%h irq=%b",
                        e.tag, sts_rd, ien_rd, irq, e.sts, e.ien, e.irq);
            end
         end
      end
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R1 reset state");
      // enable register masking
      step(0, 0, 1, 16'hFFFF, 0, 0, 0, 0, 6'h0, "R12 enable mask");
      step(1, 0, 0, 16'h0, 0, 0, 0, 0, 6'h0, "R2 buffered write sets update");
      step(0, 1, 0, 16'hFFFF, 0, 0, 0, 0, 6'h0, "R2 update flag read only");
      step(0, 0, 0, 16'h0, 1, 0, 0, 0, 6'h0, "R3 R5 R7 reload without load ok");
      idle("R13 irq follows error flag");
      step(0, 1, 0, 16'h0000, 0, 0, 0, 0, 6'h0, "R6 zero write keeps error");
      step(0, 1, 0, 16'h2000, 0, 0, 0, 0, 6'h0, "R6 error w1c");
      step(0, 0, 0, 16'h0, 1, 1, 0, 0, 6'h0, "R3 R7 valid reload clears update");
      step(0, 1, 0, 16'h1000, 0, 0, 0, 0, 6'h0, "R8 reload flag w1c");
      step(0, 0, 0, 16'h0, 1, 0, 0, 0, 6'h0, "R5 reload with update clear");
      step(0, 0, 0, 16'h0, 0, 0, 0, 1, 6'h0, "R8 dma done ignored");
      step(0, 1, 0, 16'h1000, 0, 0, 0, 0, 6'h0, "R8 reload flag w1c again");
      step(0, 0, 0, 16'h0, 1, 1, 0, 0, 6'h0, "R7 reload sets flag");
      step(0, 1, 0, 16'h1000, 0, 0, 1, 0, 6'h0, "R9 w1c ignored in dma mode");
      step(0, 0, 0, 16'h0, 0, 0, 1, 1, 6'h0, "R9 dma done clears");
      step(1, 0, 0, 16'h0, 1, 1, 0, 0, 6'h0, "R4 write with valid reload");
      step(0, 0, 0, 16'h0, 0, 0, 0, 0, 6'h2A, "R10 compare pattern a");
      step(0, 0, 0, 16'h0, 0, 0, 0, 0, 6'h15, "R10 compare pattern b");
      step(0, 1, 0, 16'h0005, 0, 0, 0, 0, 6'h0, "R10 compare w1c subset");
      step(0, 1, 0, 16'h0001, 0, 0, 0, 0, 6'h01, "R11 compare set beats clear");
      step(0, 1, 0, 16'h1000, 1, 1, 0, 0, 6'h0, "R11 reload set beats clear");
      step(1, 0, 0, 16'h0, 0, 0, 0, 0, 6'h0, "R2 update again");
      step(0, 1, 0, 16'h2000, 1, 0, 0, 0, 6'h0, "R11 error set beats clear");
      step(0, 1, 0, 16'h303F, 0, 0, 0, 0, 6'h0, "R6 R8 R10 clear all");
      step(0, 0, 0, 16'h0, 0, 0, 0, 0, 6'h04, "R13 compare with enable");
      step(0, 0, 1, 16'h0000, 0, 0, 0, 0, 6'h0, "R12 enables cleared");
      idle("R13 irq drops");
      idle("R13 irq stays low");
      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule